// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Unit

This block keeps the interrupt state of a CAN controller. Three event sources set flags in an 8-bit flag register: a frame stored in the receive buffer, a transmit request, and a receive overrun. An 8-bit enable register masks the flags, and a single level interrupt line is high while any enabled flag is set. The irq output is a pure function of the two registers, so it follows every flag or enable change with no extra delay.

The host reaches the block through a plain register port. Reading the flag register returns the flags as they were and clears them in the same edge. The receive flag comes straight back if the receive buffer still reports pending messages, so a handler that reads the flags before draining the buffer cannot lose the receive interrupt. Command pulses from the receive side clear the receive flag (last message released) and the overrun flag. A small status register reports receive-buffer, overrun and transmit state. The receive storage and the bus framing live elsewhere; they reach this block only through pulses and the pending count. The register port and all pulses are single-cycle control strobes with no back-pressure: the block accepts one access in every cycle, so no valid/ready pair is needed.

Top module: `cirq_ctrl`

## Requirements
- R1: Flag register bit positions: bit 0 is receive (set by `rx_stored`), bit 1 is transmit (set by `tx_request`), bit 3 is overrun (set by `rx_overrun`); bits 2 and 4 to 7 always read 0. A set event is visible in the flag register from the cycle after the pulse.
- R2: `irq` is high exactly when the bitwise AND of the enable register and the flag register is nonzero, with no delay beyond the registers themselves.
- R3: A read of address 1 returns the flag value held before the read and clears all flags; bit 0 is set again if `pend_cnt` is nonzero in the read cycle.
- R4: If a set event coincides with a read of the flag register or with a clear command, the flag ends up set.
- R5: `rx_release_last` clears the receive flag (unless `rx_stored` in the same cycle); `clr_overrun` clears the overrun flag and status bit 1.
- R6: Status register (address 0): bit 0 = `pend_cnt` nonzero, bit 1 = overrun status (set by `rx_overrun`), bits 2 and 3 = transmit buffer free and transmit complete (set by `tx_request`, 1 after reset), bit 4 = 0, bit 5 = transmitting status, set by `tx_load` and cleared by `tx_request` (clear wins), bits 6 and 7 = 0.
- R7: Writes to address 0 (status) and address 1 (flags) change nothing.
- R8: Address 2 is an 8-bit read/write enable register, 0 after reset; address 3 reads 0.
- R9: After reset all flags are 0, `irq` is low and status reads 0x0C plus the pending bit.
- R10: A read with `reg_en` high and `reg_we` low returns its data on `reg_rdata` with `reg_rvalid` high in the next cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| rx_stored | input | 1 | Pulse: a frame was stored in the receive buffer |
| rx_overrun | input | 1 | Pulse: a frame was dropped for lack of space |
| rx_release_last | input | 1 | Pulse: the last pending message was released |
| clr_overrun | input | 1 | Pulse: clear-overrun command |
| tx_load | input | 1 | Pulse: host wrote the transmit buffer |
| tx_request | input | 1 | Pulse: transmit request issued |
| pend_cnt | input | 8 | Messages pending in the receive buffer |
| irq | output | 1 | Level interrupt |

## Verification
A wrong flag bit shows on `irq` in the very cycle after the bad update whenever its enable is set, and on `reg_rdata` at the next flag read otherwise; the bench therefore keeps a behavioural model and compares `irq` every cycle and every read result. A lost reassertion of the receive flag shows as `irq` dropping after a flag read while `pend_cnt` is nonzero. A wrong priority between set and clear appears as a missing flag in the cycle after the coincident pulses.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 2;
  localparam int FB_RX   = 0;
  localparam int FB_TX   = 1;
  localparam int FB_OVR  = 3;
  localparam int SB_PEND = 0;
  localparam int SB_OVR  = 1;
  localparam int SB_TXF  = 2;
  localparam int SB_TXC  = 3;
  localparam int SB_TXS  = 5;
  localparam logic [REG_W-1:0] FLAG_IMPL = 8'h0B;
  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 2'd0,
    A_FLAGS  = 2'd1,
    A_ENABLE = 2'd2,
    A_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cirq_flag_bank.sv
module cirq_flag_bank
  import cirq_pkg::*;
#(
  parameter int W     = REG_W,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_rx,
  input  logic             ev_tx,
  input  logic             ev_ovr,
  input  logic             rel_last,
  input  logic             clr_ovr,
  input  logic             rd_clear,
  input  logic [CNT_W-1:0] pend_cnt,
  output logic [W-1:0]     flags
);
  logic [W-1:0] set_v, clr_v, reload_v;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    reload_v = '0;
    set_v[FB_RX]  = ev_rx;
    set_v[FB_TX]  = ev_tx;
    set_v[FB_OVR] = ev_ovr;
    clr_v[FB_RX]  = rel_last;
    clr_v[FB_OVR] = clr_ovr;
    reload_v[FB_RX] = |pend_cnt;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (FLAG_IMPL[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= 1'b0;
        else if (set_v[i])   q <= 1'b1;
        else if (clr_v[i])   q <= 1'b0;
        else if (rd_clear)   q <= reload_v[i];
      end
      assign flags[i] = q;
    end else begin : g_tie
      assign flags[i] = 1'b0;
    end
  end

  a_r4_set_wins_rx: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx |=> flags[FB_RX]);
  a_r4_set_wins_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovr |=> flags[FB_OVR]);
  a_r3_read_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !ev_tx) |=> !flags[FB_TX]);
  a_r3_reassert_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !rel_last && (pend_cnt != '0)) |=> flags[FB_RX]);
  a_r5_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_last && !ev_rx) |=> !flags[FB_RX]);
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~FLAG_IMPL) == '0);
endmodule

// File: rtl/cirq_status_bank.sv
module cirq_status_bank
  import cirq_pkg::*;
#(
  parameter int W     = REG_W,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_ovr,
  input  logic             clr_ovr,
  input  logic             tx_load,
  input  logic             tx_req,
  input  logic [CNT_W-1:0] pend_cnt,
  output logic [W-1:0]     status
);
  logic ovr_q, txs_q, txf_q, txc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      txs_q <= 1'b0;
      txf_q <= 1'b1;
      txc_q <= 1'b1;
    end else begin
      if (ev_ovr)       ovr_q <= 1'b1;
      else if (clr_ovr) ovr_q <= 1'b0;
      if (tx_req)       txs_q <= 1'b0;
      else if (tx_load) txs_q <= 1'b1;
      if (tx_req) begin
        txf_q <= 1'b1;
        txc_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status = '0;
    status[SB_PEND] = |pend_cnt;
    status[SB_OVR]  = ovr_q;
    status[SB_TXF]  = txf_q;
    status[SB_TXC]  = txc_q;
    status[SB_TXS]  = txs_q;
  end

  a_r6_tx_done: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> (status[SB_TXC] && status[SB_TXF] && !status[SB_TXS]));
  a_r6_tx_load: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !tx_req) |=> status[SB_TXS]);
  a_r5_clr_ovr_status: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovr && !ev_ovr) |=> !status[SB_OVR]);
endmodule

// File: rtl/cirq_regport.sv
module cirq_regport
  import cirq_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  input  logic [W-1:0]  status,
  input  logic [W-1:0]  flags,
  output logic [W-1:0]  enable,
  output logic          rd_clear,
  output logic [W-1:0]  reg_rdata,
  output logic          reg_rvalid
);
  logic         rd, wr;
  logic [W-1:0] rmux;

  assign rd = reg_en && !reg_we;
  assign wr = reg_en && reg_we;
  assign rd_clear = rd && (reg_addr == A_FLAGS);

  always_comb begin
    unique case (reg_addr)
      A_STATUS: rmux = status;
      A_FLAGS:  rmux = flags;
      A_ENABLE: rmux = enable;
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable     <= '0;
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      if (wr && reg_addr == A_ENABLE) enable <= reg_wdata;
      reg_rvalid <= rd;
      if (rd) reg_rdata <= rmux;
    end
  end

  a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> reg_rvalid);
  a_r10_rvalid_only: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !reg_rvalid);
  a_r7_enable_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && reg_addr == A_ENABLE) |=> $stable(enable));
endmodule

// File: rtl/cirq_ctrl.sv
module cirq_ctrl
  import cirq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              reg_rvalid,
  input  logic              rx_stored,
  input  logic              rx_overrun,
  input  logic              rx_release_last,
  input  logic              clr_overrun,
  input  logic              tx_load,
  input  logic              tx_request,
  input  logic [CNT_W-1:0]  pend_cnt,
  output logic              irq
);
  logic [REG_W-1:0] flags, status, enable;
  logic             rd_clear;

  cirq_flag_bank #(.W(REG_W), .CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .ev_rx(rx_stored), .ev_tx(tx_request), .ev_ovr(rx_overrun),
    .rel_last(rx_release_last), .clr_ovr(clr_overrun),
    .rd_clear(rd_clear), .pend_cnt(pend_cnt), .flags(flags)
  );

  cirq_status_bank #(.W(REG_W), .CNT_W(CNT_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .ev_ovr(rx_overrun), .clr_ovr(clr_overrun),
    .tx_load(tx_load), .tx_req(tx_request),
    .pend_cnt(pend_cnt), .status(status)
  );

  cirq_regport #(.W(REG_W), .AW(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status(status), .flags(flags),
    .enable(enable), .rd_clear(rd_clear),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  assign irq = |(enable & flags);

  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);
  a_r2_tx_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_request && enable[FB_TX] && !(reg_en && reg_we && reg_addr == A_ENABLE)) |=> irq);
endmodule

// File: tb/cirq_ctrl_test.sv
`timescale 1ns/1ps
module cirq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_en = 0, reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       reg_rvalid;
  logic       rx_stored = 0, rx_overrun = 0, rx_release_last = 0;
  logic       clr_overrun = 0, tx_load = 0, tx_request = 0;
  logic [7:0] pend_cnt = 0;
  logic       irq;

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural model
  logic [7:0] m_flags = 0, m_en = 0, m_rdata = 0;
  logic       m_ovs = 0, m_txs = 0, m_rv = 0;

  always #2.5 clk = ~clk;

  cirq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .rx_stored(rx_stored), .rx_overrun(rx_overrun),
    .rx_release_last(rx_release_last), .clr_overrun(clr_overrun),
    .tx_load(tx_load), .tx_request(tx_request), .pend_cnt(pend_cnt), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    return {2'b00, m_txs, 1'b0, 2'b11, m_ovs, |pend_cnt};
  endfunction

  // one clock: model the edge, then compare away from it
  task automatic cycle();
    logic [7:0] nf;
    bit rd;
    @(posedge clk);
    rd = reg_en && !reg_we;
    m_rv = rd;
    if (rd) m_rdata = (reg_addr == 0) ? m_status() : (reg_addr == 1) ? m_flags :
                      (reg_addr == 2) ? m_en : 8'h00;
    nf = m_flags;
    if (rd && reg_addr == 1) nf = {7'b0, |pend_cnt};
    if (rx_release_last) nf[0] = 0;
    if (clr_overrun) nf[3] = 0;
    if (rx_stored) nf[0] = 1;
    if (tx_request) nf[1] = 1;
    if (rx_overrun) nf[3] = 1;
    m_flags = nf;
    if (reg_en && reg_we && reg_addr == 2) m_en = reg_wdata;
    if (rx_overrun) m_ovs = 1; else if (clr_overrun) m_ovs = 0;
    if (tx_request) m_txs = 0; else if (tx_load) m_txs = 1;
    @(negedge clk);
    chk("R2 irq vs model", {7'b0, irq}, {7'b0, |(m_en & m_flags)});
    chk("R10 rvalid vs model", {7'b0, reg_rvalid}, {7'b0, m_rv});
    if (m_rv) chk("R10 rdata vs model", reg_rdata, m_rdata);
    reg_en = 0; reg_we = 0;
    rx_stored = 0; rx_overrun = 0; rx_release_last = 0;
    clr_overrun = 0; tx_load = 0; tx_request = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input string tag, input logic [7:0] exp);
    reg_en = 1; reg_we = 0; reg_addr = a;
    cycle();
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 irq after reset", {7'b0, irq}, 8'h00);
    rd_reg(2'd0, "R9 status after reset", 8'h0C);
    rd_reg(2'd1, "R9 flags after reset", 8'h00);
    rd_reg(2'd2, "R8 enable after reset", 8'h00);
    rd_reg(2'd3, "R8 spare address", 8'h00);
    // R8 enable r/w
    wr_reg(2'd2, 8'hA5);
    rd_reg(2'd2, "R8 enable readback", 8'hA5);
    wr_reg(2'd2, 8'h00);
    // R1 set events, R2 masked irq
    rx_stored = 1; tx_request = 1; cycle();
    chk("R2 irq masked off", {7'b0, irq}, 8'h00);
    rx_overrun = 1; cycle();
    rd_reg(2'd1, "R1 flags rx tx ovr", 8'h0B);
    rd_reg(2'd1, "R3 flags cleared by read", 8'h00);
    // R2 enable per bit
    wr_reg(2'd2, 8'h02);
    rx_stored = 1; cycle();
    chk("R2 rx not enabled", {7'b0, irq}, 8'h00);
    tx_request = 1; cycle();
    chk("R2 tx enabled raises irq", {7'b0, irq}, 8'h01);
    // R3 reassert with pending
    wr_reg(2'd2, 8'h01);
    pend_cnt = 8'd2;
    rd_reg(2'd1, "R3 old value returned", 8'h03);
    chk("R3 irq kept by reassert", {7'b0, irq}, 8'h01);
    rd_reg(2'd1, "R3 rx reasserted", 8'h01);
    // R5 release last
    pend_cnt = 8'd0; rx_release_last = 1; cycle();
    chk("R5 irq after release last", {7'b0, irq}, 8'h00);
    rd_reg(2'd1, "R5 rx cleared by release", 8'h00);
    // R4 set wins over read clear
    reg_en = 1; reg_we = 0; reg_addr = 2'd1; tx_request = 1; cycle();
    rd_reg(2'd1, "R4 tx set beats read clear", 8'h02);
    rx_stored = 1; rx_release_last = 1; cycle();
    rd_reg(2'd1, "R4 rx set beats release", 8'h01);
    rx_overrun = 1; clr_overrun = 1; cycle();
    rd_reg(2'd0, "R4 overrun status set wins", 8'h0E);
    // R5 clear overrun
    wr_reg(2'd2, 8'h08);
    rx_overrun = 1; cycle();
    chk("R2 overrun irq", {7'b0, irq}, 8'h01);
    clr_overrun = 1; cycle();
    chk("R5 clr overrun drops irq", {7'b0, irq}, 8'h00);
    rd_reg(2'd0, "R5 overrun status cleared", 8'h0C);
    // R6 transmit status
    tx_load = 1; cycle();
    rd_reg(2'd0, "R6 tx_load sets bit5", 8'h2C);
    tx_request = 1; cycle();
    rd_reg(2'd0, "R6 tx_request clears bit5", 8'h0C);
    tx_load = 1; tx_request = 1; cycle();
    pend_cnt = 8'd1;
    rd_reg(2'd0, "R6 clear wins, pending bit", 8'h0D);
    // R7 writes to status/flags ignored
    rd_reg(2'd1, "R7 prep flags", 8'h02);
    rx_stored = 1; cycle();
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd0, 8'hFF);
    rd_reg(2'd1, "R7 flag write ignored", 8'h01);
    pend_cnt = 8'd0;
    rd_reg(2'd0, "R7 status write ignored", 8'h0C);
    // R10 rvalid only after a read
    reg_en = 1; reg_we = 1; reg_addr = 2'd3; reg_wdata = 8'h55; cycle();
    chk("R10 no rvalid after write", {7'b0, reg_rvalid}, 8'h00);
    // R9 reset mid-run
    rx_stored = 1; tx_request = 1; cycle();
    rst_n = 0; @(negedge clk);
    m_flags = 0; m_en = 0; m_ovs = 0; m_txs = 0; m_rv = 0;
    chk("R9 irq low in reset", {7'b0, irq}, 8'h00);
    rst_n = 1; @(negedge clk);
    rd_reg(2'd1, "R9 flags cleared by reset", 8'h00);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule